// File: doc/BRIEF.md
# Make-Before-Break Tap Switch Sequencer

This block drives the switch fabric of a 128-position resistor ladder. It takes a 7-bit target position and turns it into one-hot enables for the tap switches. It also drives the switch that connects the high end of the ladder, and the switch that shunts the wiper to the low end through a resistor.

When the target moves, the switch for the new tap closes first. The switch for the old tap opens only after a programmable overlap of system clocks, so the wiper never floats between taps. A target that changes while an overlap is running waits until that overlap has finished.

Shutdown is requested by driving the run control low. In shutdown:
- every tap switch opens;
- the high end is released;
- the wiper shunt closes.

The position is kept through shutdown, and the same tap comes back when the run control returns high. If a supply-glitch flag is seen during shutdown, the kept position falls back to mid-scale.

Top module: `tap_mbb_sequencer`

## Requirements
- R1: While reset (`rst_n` low at a clock edge) is applied and after it, only tap 64 is enabled, `high_conn` is 1 and `wiper_shunt` is 0.
- R2: Bit k of `tap_en` selects tap k. Bit 0 is nearest the low terminal, bit 127 is nearest the high terminal, and a settled target code k leaves only bit k high.
- R3: A target that differs from the current tap starts an overlap one clock later. For exactly N clocks the old and the new tap bits are both high, then only the new bit stays high. N is `overlap_cycles`.
- R4: An `overlap_cycles` value of 0 is treated as an overlap of one clock.
- R5: Outside an overlap in normal mode, exactly one tap bit is high. A target equal to the current tap changes nothing.
- R6: Target changes made during an overlap do not disturb it. Once the overlap ends, the sequencer moves to the target presented at that time.
- R7: When `active_en` is low at a clock edge, from the next clock:
  - `tap_en` is all zero;
  - `high_conn` is 0 and `wiper_shunt` is 1;
  - target changes are ignored.
- R8: On leaving shutdown, the tap held before shutdown is enabled again for one clock before any new transition starts.
- R9: `supply_glitch` high at an edge where `active_en` is low resets the kept position to 64, which is the tap shown on exit.
- R10: `supply_glitch` has no effect in normal mode.
- R11: Shutdown requested during an overlap commits the new tap as the kept position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| target_pos | input | 7 | Requested tap code |
| active_en | input | 1 | 1 = normal operation, 0 = shutdown |
| supply_glitch | input | 1 | Supply dip flag; acted on only in shutdown |
| overlap_cycles | input | 4 | Make-before-break overlap length in clocks (0 acts as 1) |
| tap_en | output | 128 | One enable per tap switch |
| high_conn | output | 1 | Connects the high end of the ladder |
| wiper_shunt | output | 1 | Ties the wiper to the low end through the shunt resistor |

## Verification
The bench targets several corner cases, each of which shows up as a wrong tap count or a wrong tap:
- An overlap length that is off by one leaves two taps high for one clock too many or too few.
- A zero overlap setting that is not clamped to one produces a break-before-make gap.
- A target change during an overlap that is not deferred lets the new tap move mid-overlap.
- A shutdown that cuts an overlap short, without committing the new tap, brings the old tap back on exit.

It also runs a supply glitch both inside and outside shutdown. A design that ignored the glitch in shutdown would restore the old tap instead of mid-scale. A design that acted on it in normal mode would jump the wiper to mid-scale.

// File: rtl/tapseq_pkg.sv
// Package: shared constants and helpers for the tap sequencer.
// Assumes the tap count is a power of two given by its index width.
package tapseq_pkg;
    localparam int unsigned TAP_BITS_DEF = 7;
    localparam int unsigned OVL_BITS_DEF = 4;

    // Clamp an overlap request so that the shortest overlap is one clock.
    function automatic logic [OVL_BITS_DEF-1:0] ovl_clamp(input logic [OVL_BITS_DEF-1:0] req);
        return (req == '0) ? OVL_BITS_DEF'(1) : req;
    endfunction
endpackage

// File: rtl/tapseq_onehot.sv
// Module: decodes a tap index into a one-hot vector, gated by an enable.
// Assumes NTAPS == 2**IDX_W; a disabled decoder drives all zeros.
module tapseq_onehot #(
    parameter int unsigned IDX_W = 7,
    localparam int unsigned NTAPS = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             en,
    output logic [NTAPS-1:0] onehot
);
    genvar g;
    generate
        for (g = 0; g < NTAPS; g++) begin : g_tap
            // Each tap bit compares the index against its own code.
            assign onehot[g] = en && (idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/tapseq_timer.sv
// Module: down-counter that times the make-before-break overlap.
// Assumes load and run are never both high; expire is meaningful only while run.
module tapseq_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Load at the start of an overlap, count down while it runs, idle at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (run)    cnt <= cnt - CNT_W'(1);
        else             cnt <= '0;
    end

    assign expire = (cnt == CNT_W'(1));

    // R3: an overlap in progress always has clocks left on the timer.
    p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0));
endmodule

// File: rtl/tapseq_posctl.sv
// Module: holds the committed tap, the tap being made, and the shutdown state.
// Assumes expire comes from a timer loaded by start_ovl; targets are levels.
module tapseq_posctl #(
    parameter int unsigned IDX_W = 7,
    localparam int unsigned NTAPS = 1 << IDX_W,
    localparam logic [IDX_W-1:0] MID = IDX_W'(NTAPS / 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] target,
    input  logic             active_en,
    input  logic             glitch,
    input  logic             expire,
    output logic [IDX_W-1:0] cur_pos,
    output logic [IDX_W-1:0] new_pos,
    output logic             in_ovl,
    output logic             in_sd,
    output logic             start_ovl
);
    // An overlap starts only from a settled, powered state with a new target.
    assign start_ovl = active_en && !in_sd && !in_ovl && (target != cur_pos);

    // Position and mode state machine; shutdown and glitch take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pos <= MID;
            new_pos <= MID;
            in_ovl  <= 1'b0;
            in_sd   <= 1'b0;
        end else if (!active_en) begin
            if (in_ovl) cur_pos <= new_pos;
            if (glitch) cur_pos <= MID;
            in_ovl <= 1'b0;
            in_sd  <= 1'b1;
        end else if (in_sd) begin
            in_sd <= 1'b0;
        end else if (in_ovl) begin
            if (expire) begin
                cur_pos <= new_pos;
                in_ovl  <= 1'b0;
            end
        end else if (start_ovl) begin
            new_pos <= target;
            in_ovl  <= 1'b1;
        end
    end

    // R9: a glitch seen during shutdown lands the kept tap at mid-scale.
    p_glitch_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_en && glitch) |=> (cur_pos == MID));

    // R8: without a glitch, the kept tap does not move while in shutdown.
    p_hold_sd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sd && !active_en && !glitch) |=> $stable(cur_pos));
endmodule

// File: rtl/tap_mbb_sequencer.sv
// Module: top of the make-before-break tap sequencer.
// Drives one-hot tap enables plus the high-end and wiper-shunt switches.
// Assumes all inputs are synchronous to clk.
module tap_mbb_sequencer #(
    parameter int unsigned IDX_W = tapseq_pkg::TAP_BITS_DEF,
    parameter int unsigned OVL_W = tapseq_pkg::OVL_BITS_DEF,
    localparam int unsigned NTAPS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       target_pos,
    input  logic             active_en,
    input  logic             supply_glitch,
    input  logic [3:0]       overlap_cycles,
    output logic [127:0]     tap_en,
    output logic             high_conn,
    output logic             wiper_shunt
);
    logic [IDX_W-1:0] cur_pos, new_pos;
    logic             in_ovl, in_sd, start_ovl, expire;
    logic [NTAPS-1:0] hot_cur, hot_new;
    logic [OVL_W-1:0] ovl_len;

    // Overlap length with the zero request lifted to one clock.
    assign ovl_len = tapseq_pkg::ovl_clamp(OVL_W'(overlap_cycles));

    tapseq_posctl #(.IDX_W(IDX_W)) i_posctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .target    (IDX_W'(target_pos)),
        .active_en (active_en),
        .glitch    (supply_glitch),
        .expire    (expire),
        .cur_pos   (cur_pos),
        .new_pos   (new_pos),
        .in_ovl    (in_ovl),
        .in_sd     (in_sd),
        .start_ovl (start_ovl)
    );

    tapseq_timer #(.CNT_W(OVL_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ovl),
        .load_val (ovl_len),
        .run      (in_ovl),
        .expire   (expire)
    );

    tapseq_onehot #(.IDX_W(IDX_W)) i_dec_cur (
        .idx    (cur_pos),
        .en     (!in_sd),
        .onehot (hot_cur)
    );

    tapseq_onehot #(.IDX_W(IDX_W)) i_dec_new (
        .idx    (new_pos),
        .en     (!in_sd && in_ovl),
        .onehot (hot_new)
    );

    // Merge the held tap and the tap being made into the switch enables.
    assign tap_en      = 128'(hot_cur | hot_new);
    assign high_conn   = !in_sd;
    assign wiper_shunt = in_sd;

    // R5: in normal mode one or two taps are on, never zero or more than two.
    p_tap_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        high_conn |-> ($countones(tap_en) == 1 || $countones(tap_en) == 2));

    // R7: with the shunt closed, every tap switch is open.
    p_sd_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wiper_shunt |-> (tap_en == '0));

    // R3: a single tap is never replaced by another single tap in one step.
    p_mbb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (high_conn && $past(high_conn) && $countones($past(tap_en)) == 1
            && tap_en != $past(tap_en)) |-> ($countones(tap_en) == 2));

    // R3: when the second tap drops, the survivor was already on.
    p_break_after_make_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (high_conn && $past(high_conn) && $countones($past(tap_en)) == 2
            && $countones(tap_en) == 1) |-> ((tap_en & $past(tap_en)) == tap_en));
endmodule

// File: tb/test_tap_mbb_sequencer.sv
// Bench: behavioural reference model compared against the outputs every clock.
module test_tap_mbb_sequencer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [6:0]   target_pos = 7'd64;
    logic         active_en = 1'b1;
    logic         supply_glitch = 1'b0;
    logic [3:0]   overlap_cycles = 4'd1;
    logic [127:0] tap_en;
    logic         high_conn, wiper_shunt;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    done     = 0;

    // Reference model state.
    int m_cur = 64, m_new = 64, m_cnt = 0;
    bit m_ovl = 0, m_sd = 0;

    always #4 clk = ~clk;

    tap_mbb_sequencer i_tap_mbb_sequencer (
        .clk(clk), .rst_n(rst_n), .target_pos(target_pos),
        .active_en(active_en), .supply_glitch(supply_glitch),
        .overlap_cycles(overlap_cycles), .tap_en(tap_en),
        .high_conn(high_conn), .wiper_shunt(wiper_shunt)
    );

    // Reference model advances at each rising edge from the requirement text.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = 64; m_new = 64; m_ovl = 0; m_sd = 0; m_cnt = 0;
        end else if (!active_en) begin
            if (m_ovl) m_cur = m_new;
            if (supply_glitch) m_cur = 64;
            m_ovl = 0; m_sd = 1;
        end else if (m_sd) begin
            m_sd = 0;
        end else if (m_ovl) begin
            if (m_cnt == 1) begin m_cur = m_new; m_ovl = 0; end
            else m_cnt = m_cnt - 1;
        end else if (int'(target_pos) != m_cur) begin
            m_new = int'(target_pos); m_ovl = 1;
            m_cnt = (overlap_cycles == 0) ? 1 : int'(overlap_cycles);
        end
    end

    // Compare outputs mid-cycle.
    always @(negedge clk) begin
        logic [127:0] exp_t;
        if (!done) begin
            exp_t = '0;
            if (!m_sd) begin
                exp_t[m_cur] = 1'b1;
                if (m_ovl) exp_t[m_new] = 1'b1;
            end
            n_checks++;
            if (tap_en !== exp_t || high_conn !== !m_sd || wiper_shunt !== m_sd) begin
                n_fail++;
                $display("FAIL %s: tap_en=%h hc=%b sh=%b expected tap_en=%h hc=%b sh=%b",
                         tag, tap_en, high_conn, wiper_shunt, exp_t, !m_sd, m_sd);
            end
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run is recorded as a failure and still reports.
    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and after reset.
        tag = "R1"; wait_clk(3);
        rst_n = 1'b1; wait_clk(3);
        // R5: same target as current, nothing moves.
        tag = "R5"; target_pos = 7'd64; wait_clk(4);
        // R3: overlap of three clocks.
        tag = "R3"; overlap_cycles = 4'd3; target_pos = 7'd10; wait_clk(8);
        // R2: both ends of the ladder.
        tag = "R2"; target_pos = 7'd0; wait_clk(7);
        target_pos = 7'd127; wait_clk(7);
        // R4: a zero overlap request acts as one clock.
        tag = "R4"; overlap_cycles = 4'd0; target_pos = 7'd5; wait_clk(4);
        target_pos = 7'd6; wait_clk(4);
        // R6: target changes during a long overlap are deferred.
        tag = "R6"; overlap_cycles = 4'd6; target_pos = 7'd20; wait_clk(2);
        target_pos = 7'd30; wait_clk(2);
        target_pos = 7'd40; wait_clk(14);
        // R10: glitch in normal mode has no effect.
        tag = "R10"; supply_glitch = 1'b1; wait_clk(3); supply_glitch = 1'b0; wait_clk(2);
        // R7: shutdown, with target changes ignored.
        tag = "R7"; active_en = 1'b0; wait_clk(2); target_pos = 7'd90; wait_clk(3);
        // R8: exit restores the held tap, then moves to the new target.
        tag = "R8"; target_pos = 7'd40; active_en = 1'b1; wait_clk(3);
        target_pos = 7'd90; overlap_cycles = 4'd2; wait_clk(6);
        // R9: glitch during shutdown lands the kept tap at mid-scale.
        tag = "R9"; active_en = 1'b0; wait_clk(2);
        supply_glitch = 1'b1; wait_clk(1); supply_glitch = 1'b0; wait_clk(2);
        active_en = 1'b1; target_pos = 7'd64; wait_clk(4);
        // R11: shutdown in the middle of an overlap commits the new tap.
        tag = "R11"; overlap_cycles = 4'd8; target_pos = 7'd100; wait_clk(3);
        active_en = 1'b0; wait_clk(3);
        active_en = 1'b1; wait_clk(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule